// File: doc/BRIEF.md
# CDR Lock Acquisition Controller

This block decides, for one receive channel, whether the clock-recovery PLL should follow the incoming serial data or hold onto the local reference clock. It compares two rates. The first is the recovered word rate, after it is divided by 10 or by 20. The second is the reference tick rate, measured over a fixed window of reference ticks. The result of this comparison is combined with a run-length qualifier supplied from outside. From these the block drives a single select output, which chooses between lock-to-data and lock-to-reference. The analog loop and the VCO live elsewhere.

Both clocks enter as single-cycle count enables in the system clock domain. A three-state controller tracks three conditions: reference lock, reference lock with one passing window seen, and data lock. The controller needs two consecutive clean windows before it hands the loop to the data. It falls back to the reference as soon as any check fails. Three shared status lines report lock state. While unlocked they carry a reserved loss-of-lock code, and once the data lock is held they carry a lock-detect code.

There is no streaming data path. Every pin is a plain control or status level, so no back-pressure rules apply.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: `lock_to_data` rises only at the end of a measurement window that passed the frequency test while `rl_ok` was high, with the controller already holding one earlier pass.
- R2: A low `rl_ok` in any cycle forces `lock_to_data` low from the next cycle on, whatever the lock state.
- R3: A window spans 2^WIN_LOG2 reference ticks. It passes when the number N of divided recovered ticks counted inside it satisfies |N − 2^WIN_LOG2| ≤ floor(2^WIN_LOG2 · PPM / 10^6).
- R4: `div20_sel` = 0 divides recovered ticks by 10, and `div20_sel` = 1 divides them by 20, before they are counted.
- R5: While `lock_to_data` is low, {`st_err`,`st_eof`,`st_kflag`} = 3'b101.
- R6: While `lock_to_data` is high, {`st_err`,`st_eof`,`st_kflag`} = 3'b010.
- R7: Going from reference lock to data lock takes two consecutive passing windows. A failing window between two passes discards the first pass.
- R8: A failing window that ends while data lock is held drops `lock_to_data` at that window's end.
- R9: After reset, `lock_to_data` is low and the status lines read 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| rec_tick | input | 1 | One-cycle enable per recovered word clock period |
| div20_sel | input | 1 | 0: divide recovered ticks by 10; 1: by 20 |
| rl_ok | input | 1 | Run-length qualifier, high while run length is acceptable |
| lock_to_data | output | 1 | 1: PLL tracks data; 0: PLL tracks reference |
| st_err | output | 1 | Status line, error position |
| st_eof | output | 1 | Status line, end-of-frame position |
| st_kflag | output | 1 | Status line, K-flag position |

## Verification
The bench builds the controller with WIN_LOG2 = 6 and PPM = 50000. This gives a 64-tick window and a tolerance of 3 counts. A full window then costs about 1,300 cycles, so twenty windows fit easily. The wide tolerance makes it possible to drive a recovered rate 0.5 % slow, which must still pass. It also makes it possible to drive a rate about 7 % slow, which must fail, without long runs. Both divide settings are exercised at matching reference rates, and one divide setting is also run at a mismatched reference rate.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  typedef enum logic [1:0] {
    LK_REF   = 2'd0,
    LK_ARMED = 2'd1,
    LK_DATA  = 2'd2
  } lock_st_e;

  localparam logic [2:0] STAT_NOLOCK = 3'b101;
  localparam logic [2:0] STAT_LOCKED = 3'b010;
endpackage

// File: rtl/cdr_rec_prescaler.sv
module cdr_rec_prescaler #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_tick,
  input  logic div_hi_sel,
  output logic div_tick
);
  localparam int PW = $clog2(DIV_HI);
  localparam logic [PW-1:0] LIM_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] lim;

  assign lim      = div_hi_sel ? LIM_HI : LIM_LO;
  assign div_tick = rec_tick && (phase_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (rec_tick) begin
      if (phase_q >= lim) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
    end
  end

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick); // R4
endmodule

// File: rtl/cdr_freq_window.sv
module cdr_freq_window #(
  parameter int WIN_LOG2 = 15,
  parameter int PPM      = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic div_tick,
  output logic win_done,
  output logic win_pass
);
  localparam int  CW  = WIN_LOG2 + 2;
  localparam longint EXPV = longint'(1) << WIN_LOG2;
  localparam longint TOLV = (EXPV * PPM) / 1000000;
  localparam logic [CW-1:0] LO_B = CW'(EXPV - TOLV);
  localparam logic [CW-1:0] HI_B = CW'(EXPV + TOLV);

  logic [WIN_LOG2-1:0] ref_cnt_q;
  logic [CW-1:0]       rec_cnt_q;
  logic [CW-1:0]       total;

  assign win_done = ref_tick && (&ref_cnt_q);
  assign total    = (div_tick && !(&rec_cnt_q)) ? rec_cnt_q + 1'b1 : rec_cnt_q;
  assign win_pass = (total >= LO_B) && (total <= HI_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      rec_cnt_q <= '0;
    end else begin
      if (ref_tick) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (win_done) rec_cnt_q <= '0;
      else          rec_cnt_q <= total;
    end
  end

  AST_WIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done); // R3
  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (rec_cnt_q <= CW'(1))); // R3
endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
  import cdr_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     win_done,
  input  logic     win_pass,
  input  logic     rl_ok,
  output lock_st_e state
);
  lock_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!rl_ok) begin
      state_d = LK_REF;
    end else if (win_done) begin
      if (!win_pass) begin
        state_d = LK_REF;
      end else begin
        unique case (state_q)
          LK_REF:   state_d = LK_ARMED;
          LK_ARMED: state_d = LK_DATA;
          default:  state_d = LK_DATA;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_REF;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_DATA_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_DATA && $past(state_q) != LK_DATA)
      |-> $past(win_done && win_pass && rl_ok)); // R1
  AST_DATA_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_DATA && $past(state_q) != LK_DATA)
      |-> ($past(state_q) == LK_ARMED)); // R7
  AST_FAIL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !win_pass) |=> (state_q == LK_REF)); // R8
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
  import cdr_lock_pkg::*;
#(
  parameter int WIN_LOG2 = 15,
  parameter int PPM      = 200,
  parameter int DIV_LO   = 10,
  parameter int DIV_HI   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic rec_tick,
  input  logic div20_sel,
  input  logic rl_ok,
  output logic lock_to_data,
  output logic st_err,
  output logic st_eof,
  output logic st_kflag
);
  logic     div_tick;
  logic     win_done;
  logic     win_pass;
  lock_st_e state;
  logic [2:0] stat;

  cdr_rec_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .rec_tick(rec_tick),
    .div_hi_sel(div20_sel), .div_tick(div_tick)
  );

  cdr_freq_window #(.WIN_LOG2(WIN_LOG2), .PPM(PPM)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_tick(div_tick),
    .win_done(win_done), .win_pass(win_pass)
  );

  cdr_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .win_pass(win_pass),
    .rl_ok(rl_ok), .state(state)
  );

  assign lock_to_data = (state == LK_DATA);
  assign stat         = lock_to_data ? STAT_LOCKED : STAT_NOLOCK;
  assign st_err       = stat[2];
  assign st_eof       = stat[1];
  assign st_kflag     = stat[0];

  AST_RL_FORCES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !rl_ok |=> !lock_to_data); // R2
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_err, st_eof, st_kflag}) == (lock_to_data ? 1 : 2)); // R5
endmodule

// File: tb/sim_cdr_lock_ctrl.sv
`timescale 1ns/1ps
module sim_cdr_lock_ctrl;
  localparam int W   = 6;
  localparam int PPM = 50000;
  localparam int NREF = 1 << W;

  logic clk = 1'b0;
  logic rst_n, ref_tick, rec_tick, div20_sel, rl_ok;
  logic lock_to_data, st_err, st_eof, st_kflag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rl_level = 1'b1;
  bit exp_q[$];
  event win_ev;

  always #5 clk = ~clk;

  cdr_lock_ctrl #(.WIN_LOG2(W), .PPM(PPM)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rec_tick(rec_tick),
    .div20_sel(div20_sel), .rl_ok(rl_ok), .lock_to_data(lock_to_data),
    .st_err(st_err), .st_eof(st_eof), .st_kflag(st_kflag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(input bit r, input int skip, input bit drop);
    ref_tick = r;
    rec_tick = (skip == 0) || ((cyc % skip) != skip - 1);
    rl_ok    = rl_level && !drop;
    @(negedge clk);
    cyc++;
  endtask

  // Driver: one full window; pushes the expected lock state for its end.
  task automatic run_window(input int period, input int skip, input bit expv,
                            input int drop_at);
    for (int p = 0; p < NREF; p++) begin
      for (int c = 0; c < period; c++) begin
        tick(c == 0, skip, (p == drop_at) && (c == 0));
        if (p == NREF - 1 && c == 0) begin
          exp_q.push_back(expv);
          -> win_ev;
        end
        if (p == drop_at && c == 0)
          chk(lock_to_data == 1'b0, "R2 run-length drop", lock_to_data, 0);
      end
    end
  endtask

  // Monitor: compares lock and status at each window end.
  initial begin
    forever begin
      @(win_ev);
      begin
        bit e;
        e = exp_q.pop_front();
        chk(lock_to_data == e, "R1/R3/R7/R8 lock at window end", lock_to_data, e);
        if (e) chk({st_err, st_eof, st_kflag} == 3'b010, "R6 locked status",
                   {st_err, st_eof, st_kflag}, 3'b010);
        else   chk({st_err, st_eof, st_kflag} == 3'b101, "R5 unlocked status",
                   {st_err, st_eof, st_kflag}, 3'b101);
      end
    end
  end

  initial begin
    #(1_500_000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; rec_tick = 1'b0; div20_sel = 1'b1; rl_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(lock_to_data == 1'b0, "R9 reset lock", lock_to_data, 0);
    chk({st_err, st_eof, st_kflag} == 3'b101, "R9 reset status",
        {st_err, st_eof, st_kflag}, 3'b101);

    // Divide-by-20 at a matching reference period of 20 cycles.
    run_window(20, 0, 1'b0, -1);   // R7 first pass only arms
    run_window(20, 0, 1'b1, -1);   // R1 second pass locks
    run_window(20, 200, 1'b1, -1); // R3 0.5 % slow, inside tolerance
    run_window(20, 14, 1'b0, -1);  // R8 about 7 % slow, outside tolerance
    run_window(20, 0, 1'b0, -1);   // R7
    run_window(20, 14, 1'b0, -1);  // R7 failing window discards the pass
    run_window(20, 0, 1'b0, -1);   // R7
    run_window(20, 0, 1'b1, -1);   // R1
    run_window(20, 0, 1'b0, 10);   // R2 drop mid-window, then one pass
    run_window(20, 0, 1'b1, -1);   // R1
    rl_level = 1'b0;
    run_window(20, 0, 1'b0, -1);   // R1 qualifier low blocks lock
    rl_level = 1'b1;
    run_window(20, 0, 1'b0, -1);   // R1 needs two passes again
    // R4: divide-by-10 against a 20-cycle reference gives twice the count.
    div20_sel = 1'b0;
    run_window(20, 0, 1'b0, -1);   // R4 mismatch fails
    run_window(20, 0, 1'b0, -1);   // R4 mismatch fails

    // R4: divide-by-10 at a matching reference period of 10 cycles.
    rst_n = 1'b0;
    tick(1'b0, 0, 1'b0);
    tick(1'b0, 0, 1'b0);
    rst_n = 1'b1;
    chk(lock_to_data == 1'b0, "R9 second reset", lock_to_data, 0);
    run_window(10, 0, 1'b0, -1);   // R4
    run_window(10, 0, 1'b1, -1);   // R4 locks in divide-by-10 mode
    run_window(10, 8, 1'b0, -1);   // R8 12.5 % slow drops lock

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule